// File: doc/BRIEF.md
# Passive Monochrome LCD Panel Timing Generator

This block drives a passive monochrome LCD panel directly from the pixel clock. It reads pixel words from a line buffer through a simple address/data read port. It serialises those words onto a 1, 2 or 4 lane data bus under a shift clock. At the end of every line it produces a line pulse and asks the line buffer to refill. It also produces a frame marker around the first line of each frame and an alternating-polarity signal for the liquid crystal.

Software programs the geometry: words per line and rows per frame. It also programs the bus width, the polarity of the shift clock, line pulse and frame marker, the alternation period, pixel inversion and lane reversal. A single enable bit starts and stops refresh. Stopping always happens at a line boundary. Starting always begins a new frame at row 0.

Top module: `lcd_tg`

## Requirements
- R1: `cfg_bus` selects the lane count: 0 gives 1 lane, 1 gives 2 lanes, 2 or 3 gives 4 lanes. Pixel j of a word is `rd_data[j]`. Words are read at `rd_addr` 0 up to `cfg_words`, in order. Within a beat the earliest pixel goes to LD lane 0, and lanes not in use are driven low.
- R2: Each beat lasts two cycles, with the shift clock inactive and then active. A line has (`cfg_words`+1)·WORD_W/lanes beats. Outside beats the shift clock stays inactive.
- R3: After the last beat of a line the line pulse is active for exactly 8 cycles. During the pulse the shift clock is inactive and LD is all zero.
- R4: `buf_req` pulses high for one cycle in the first cycle of every line pulse. It also pulses one cycle before the first beat after enabling.
- R5: The frame marker becomes active when the line pulse of row 0 ends. It becomes inactive when the next line pulse starts, and is inactive otherwise.
- R6: `cfg_pol` bit 0, bit 1 and bit 2 make the shift clock, line pulse and frame marker active low when set. When cleared, the signal is active high.
- R7: `lacd` toggles when the line pulse of the last row ends, once every `cfg_acd`+1 frames.
- R8: With `cfg_inv` set, every pixel value on the used lanes is inverted.
- R9: With `cfg_rev` set, LD lane k carries what lane 3-k would otherwise carry.
- R10: A frame has `cfg_rows`+1 lines (9-bit field, up to 512 rows).
- R11: When `en` is low at the end of a line's last beat, the block halts there. It produces no line pulse and no request, and the marker and data are inactive. Setting `en` again issues a request and restarts at row 0 of a new frame.
- R12: After reset the block is halted, with LD at 0, `lacd` at 0, `buf_req` at 0 and all strobes at their inactive levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Refresh enable |
| cfg_words | input | WB | Words per line minus one |
| cfg_rows | input | RB | Rows per frame minus one |
| cfg_bus | input | 2 | Lane count select |
| cfg_pol | input | 3 | Active-low select: shift clock, line pulse, frame marker |
| cfg_acd | input | AB | Alternation period in frames minus one |
| cfg_inv | input | 1 | Invert pixel data |
| cfg_rev | input | 1 | Reverse lane order |
| rd_addr | output | WB | Line buffer word address |
| rd_data | input | WORD_W | Line buffer word, one bit per pixel |
| buf_req | output | 1 | Line buffer refill request pulse |
| ld | output | LD_W | Panel data lanes |
| lclk | output | 1 | Shift clock |
| lp | output | 1 | Line pulse |
| flm | output | 1 | First-line frame marker |
| lacd | output | 1 | Alternating polarity output |

## Verification
The bench sweeps all four bus codes against every inversion and reversal combination. Each sweep uses its own polarity, line length and alternation period, so lane selection, bit order within a word and word addressing are each separated from the others. The line buffer content changes with every refill request. A wrong word, a stale line or a misplaced lane therefore shows up as a data mismatch on some beat. A one-row frame with a 16-frame alternation period separates the marker and alternation logic from the row counter. Every run ends by dropping the enable, which shows that the halt waits for the line end and that the restart begins at row 0.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_PREP  = 2'd1,
      ST_SHIFT = 2'd2,
      ST_LP    = 2'd3
   } tg_state_e;

   function automatic logic [2:0] lane_count(input logic [1:0] code);
      case (code)
         2'd0:    lane_count = 3'd1;
         2'd1:    lane_count = 3'd2;
         default: lane_count = 3'd4;
      endcase
   endfunction
endpackage

// File: rtl/lcd_tg_seq.sv
module lcd_tg_seq
   import lcd_tg_pkg::*;
#(
   parameter int WORD_W = 8,
   parameter int WB     = 8,
   parameter int RB     = 9,
   parameter int AB     = 4,
   parameter int LPW    = 8,
   localparam int OFFW  = $clog2(WORD_W),
   localparam int LPCW  = $clog2(LPW)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic [WB-1:0]   cfg_words,
   input  logic [RB-1:0]   cfg_rows,
   input  logic [1:0]      cfg_bus,
   input  logic [AB-1:0]   cfg_acd,
   output logic [WB-1:0]   rd_addr,
   output logic [OFFW-1:0] off,
   output logic            shifting,
   output logic            lclk_act,
   output logic            lp_act,
   output logic            flm_act,
   output logic            lacd,
   output logic            req
);
   tg_state_e       st;
   logic            ph;
   logic [LPCW-1:0] lpc;
   logic [RB-1:0]   row;
   logic [AB-1:0]   fcnt;
   logic [OFFW:0]   nxt_off;
   logic            word_done;

   assign nxt_off   = {1'b0, off} + (OFFW+1)'(lane_count(cfg_bus));
   assign word_done = (nxt_off >= (OFFW+1)'(WORD_W));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         ph      <= 1'b0;
         lpc     <= '0;
         row     <= '0;
         fcnt    <= '0;
         rd_addr <= '0;
         off     <= '0;
         flm_act <= 1'b0;
         lacd    <= 1'b0;
      end else begin
         case (st)
            ST_IDLE: if (en) st <= ST_PREP;
            ST_PREP: begin
               st      <= ST_SHIFT;
               ph      <= 1'b0;
               rd_addr <= '0;
               off     <= '0;
               row     <= '0;
               fcnt    <= '0;
               flm_act <= 1'b0;
            end
            ST_SHIFT: begin
               ph <= ~ph;
               if (ph) begin
                  if (word_done) begin
                     off <= '0;
                     if (rd_addr == cfg_words) begin
                        flm_act <= 1'b0;
                        lpc     <= '0;
                        st      <= en ? ST_LP : ST_IDLE;
                     end else begin
                        rd_addr <= rd_addr + 1'b1;
                     end
                  end else begin
                     off <= nxt_off[OFFW-1:0];
                  end
               end
            end
            ST_LP: begin
               lpc <= lpc + 1'b1;
               if (lpc == LPCW'(LPW-1)) begin
                  st      <= ST_SHIFT;
                  ph      <= 1'b0;
                  rd_addr <= '0;
                  off     <= '0;
                  flm_act <= (row == '0);
                  if (row == cfg_rows) begin
                     row <= '0;
                     if (fcnt == cfg_acd) begin
                        fcnt <= '0;
                        lacd <= ~lacd;
                     end else begin
                        fcnt <= fcnt + 1'b1;
                     end
                  end else begin
                     row <= row + 1'b1;
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign shifting = (st == ST_SHIFT);
   assign lclk_act = shifting & ph;
   assign lp_act   = (st == ST_LP);
   assign req      = (st == ST_PREP) | (lp_act & (lpc == '0));
endmodule

// File: rtl/lcd_tg_pix.sv
module lcd_tg_pix
   import lcd_tg_pkg::*;
#(
   parameter int WORD_W = 8,
   parameter int LD_W   = 4,
   parameter bit REV_EN = 1'b1,
   localparam int OFFW  = $clog2(WORD_W)
) (
   input  logic [WORD_W-1:0] word,
   input  logic [OFFW-1:0]   off,
   input  logic [1:0]        cfg_bus,
   input  logic              inv,
   input  logic              rev,
   input  logic              shifting,
   output logic [LD_W-1:0]   ld
);
   logic [LD_W-1:0] raw;
   logic [2:0]      nl;

   assign nl = lane_count(cfg_bus);

   for (genvar k = 0; k < LD_W; k++) begin : g_lane
      logic [OFFW-1:0] idx;
      assign idx    = off + OFFW'(k);
      assign raw[k] = shifting & (3'(k) < nl) & (word[idx] ^ inv);
   end

   if (REV_EN) begin : g_rev
      for (genvar k = 0; k < LD_W; k++) begin : g_bit
         assign ld[k] = rev ? raw[LD_W-1-k] : raw[k];
      end
   end else begin : g_fwd
      assign ld = raw;
   end
endmodule

// File: rtl/lcd_tg.sv
module lcd_tg #(
   parameter int WORD_W = 8,
   parameter int WB     = 8,
   parameter int RB     = 9,
   parameter int AB     = 4,
   parameter int LPW    = 8,
   parameter int LD_W   = 4,
   parameter bit REV_EN = 1'b1,
   localparam int OFFW  = $clog2(WORD_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [WB-1:0]     cfg_words,
   input  logic [RB-1:0]     cfg_rows,
   input  logic [1:0]        cfg_bus,
   input  logic [2:0]        cfg_pol,
   input  logic [AB-1:0]     cfg_acd,
   input  logic              cfg_inv,
   input  logic              cfg_rev,
   output logic [WB-1:0]     rd_addr,
   input  logic [WORD_W-1:0] rd_data,
   output logic              buf_req,
   output logic [LD_W-1:0]   ld,
   output logic              lclk,
   output logic              lp,
   output logic              flm,
   output logic              lacd
);
   if (WORD_W < 4 || (WORD_W & (WORD_W - 1)) != 0) begin : g_bad_word
      $error("WORD_W must be a power of two of at least 4");
   end
   if (LD_W != 4) begin : g_bad_lanes
      $error("LD_W must be 4");
   end
   if (LPW < 2 || (LPW & (LPW - 1)) != 0) begin : g_bad_lpw
      $error("LPW must be a power of two of at least 2");
   end

   logic [OFFW-1:0] off;
   logic            shifting, lclk_act, lp_act, flm_act;

   lcd_tg_seq #(
      .WORD_W(WORD_W), .WB(WB), .RB(RB), .AB(AB), .LPW(LPW)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .en(en),
      .cfg_words(cfg_words), .cfg_rows(cfg_rows), .cfg_bus(cfg_bus), .cfg_acd(cfg_acd),
      .rd_addr(rd_addr), .off(off), .shifting(shifting),
      .lclk_act(lclk_act), .lp_act(lp_act), .flm_act(flm_act),
      .lacd(lacd), .req(buf_req)
   );

   lcd_tg_pix #(
      .WORD_W(WORD_W), .LD_W(LD_W), .REV_EN(REV_EN)
   ) u_pix (
      .word(rd_data), .off(off), .cfg_bus(cfg_bus),
      .inv(cfg_inv), .rev(cfg_rev), .shifting(shifting), .ld(ld)
   );

   assign lclk = lclk_act ^ cfg_pol[0];
   assign lp   = lp_act   ^ cfg_pol[1];
   assign flm  = flm_act  ^ cfg_pol[2];
endmodule

// File: rtl/lcd_tg_chk.sv
module lcd_tg_chk #(
   parameter int LD_W = 4,
   parameter int LPW  = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic [2:0]      cfg_pol,
   input logic            lclk,
   input logic            lp,
   input logic            flm,
   input logic            lacd,
   input logic [LD_W-1:0] ld,
   input logic            buf_req
);
   logic   la, pa, fa;
   logic [7:0] run;

   assign la = lclk ^ cfg_pol[0];
   assign pa = lp   ^ cfg_pol[1];
   assign fa = flm  ^ cfg_pol[2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run <= '0;
      else        run <= pa ? run + 1'b1 : '0;
   end

   a_r3_lp_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      pa |-> run < 8'(LPW));
   a_r3_lp_full: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pa) |-> run == 8'(LPW));
   a_r3_quiet_in_lp: assert property (@(posedge clk) disable iff (!rst_n)
      pa |-> (!la && ld == '0));
   a_r2_lclk_single: assert property (@(posedge clk) disable iff (!rst_n)
      la |=> !la);
   a_r4_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      buf_req |=> !buf_req);
   a_r5_flm_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fa) |-> $fell(pa));
   a_r5_flm_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fa) |-> !la);
   a_r7_acd_at_frame: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(lacd) |-> $fell(pa));
endmodule

bind lcd_tg lcd_tg_chk #(.LD_W(LD_W), .LPW(LPW)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_pol(cfg_pol), .lclk(lclk), .lp(lp),
   .flm(flm), .lacd(lacd), .ld(ld), .buf_req(buf_req)
);

// File: tb/sim_lcd_tg.sv
module sim_lcd_tg;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic [7:0] cfg_words = 8'd1;
   logic [8:0] cfg_rows = 9'd2;
   logic [1:0] cfg_bus = 2'd0;
   logic [2:0] cfg_pol = 3'd0;
   logic [3:0] cfg_acd = 4'd0;
   logic       cfg_inv = 1'b0;
   logic       cfg_rev = 1'b0;
   logic [7:0] rd_addr;
   logic [7:0] rd_data;
   logic       buf_req;
   logic [3:0] ld;
   logic       lclk, lp, flm, lacd;

   int checks = 0, errors = 0, cycles = 0;
   int reqcnt = 0, bc = 0, lpw = 0, lines = 0, frames = 0, lc = 0, prevrow = 0;
   int rows = 3, nfr = 1, beats = 0;
   bit run_on = 1'b0, pprev = 1'b0;
   logic acd0 = 1'b0;

   always #4 clk = ~clk;

   function automatic logic [7:0] pat(input int seed, input int a);
      return 8'((a * 37 + seed * 101 + 13) ^ (seed << 3));
   endfunction

   assign rd_data = pat(reqcnt, int'(rd_addr));

   lcd_tg u0 (
      .clk(clk), .rst_n(rst_n), .en(en), .cfg_words(cfg_words), .cfg_rows(cfg_rows),
      .cfg_bus(cfg_bus), .cfg_pol(cfg_pol), .cfg_acd(cfg_acd), .cfg_inv(cfg_inv),
      .cfg_rev(cfg_rev), .rd_addr(rd_addr), .rd_data(rd_data), .buf_req(buf_req),
      .ld(ld), .lclk(lclk), .lp(lp), .flm(flm), .lacd(lacd)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int lanes();
      return (cfg_bus == 2'd0) ? 1 : (cfg_bus == 2'd1) ? 2 : 4;
   endfunction

   function automatic logic [3:0] exp_ld(input int b);
      int nl = lanes();
      int p0 = b * nl;
      logic [7:0] w = pat(reqcnt, p0 / 8);
      logic [3:0] raw = '0;
      logic [3:0] r;
      for (int k = 0; k < nl; k++) raw[k] = w[(p0 % 8) + k] ^ cfg_inv;
      for (int k = 0; k < 4; k++) r[k] = cfg_rev ? raw[3 - k] : raw[k];
      return r;
   endfunction

   always @(negedge clk) begin
      cycles++;
      if (run_on) begin
         logic la, pa, fa;
         la = lclk ^ cfg_pol[0];
         pa = lp ^ cfg_pol[1];
         fa = flm ^ cfg_pol[2];
         if (buf_req) reqcnt++;
         if (la) begin
            chk(ld == exp_ld(bc), "R1 R8 R9 lane data", int'(ld), int'(exp_ld(bc)));
            if (bc == 0) begin
               chk(fa == (lines > 0 && prevrow == 0), "R5 R10 frame marker",
                   int'(fa), int'(lines > 0 && prevrow == 0));
               chk(lacd == (acd0 ^ (((frames / (int'(cfg_acd) + 1)) % 2) == 1)),
                   "R7 alternation", int'(lacd),
                   int'(acd0 ^ (((frames / (int'(cfg_acd) + 1)) % 2) == 1)));
            end
            bc++;
         end
         if (pa && !pprev) begin
            chk(bc == beats, "R2 beats per line", bc, beats);
            chk(buf_req == 1'b1, "R4 request at line pulse", int'(buf_req), 1);
            chk(ld == 4'd0 && !la, "R3 quiet during pulse", int'(ld), 0);
         end
         if (pa) lpw++;
         if (!pa && pprev) begin
            chk(lpw == 8, "R3 pulse width", lpw, 8);
            prevrow = lc;
            lines++;
            lc = (lc + 1 == rows) ? 0 : lc + 1;
            if (lc == 0) frames++;
            bc = 0;
            lpw = 0;
         end
         pprev = pa;
      end
   end

   task automatic run_cfg(input int bus, input bit inv, input bit rev, input int pol,
                          input int words, input int nrows, input int acdn, input int nframes);
      @(negedge clk);
      cfg_bus = 2'(bus); cfg_inv = inv; cfg_rev = rev; cfg_pol = 3'(pol);
      cfg_words = 8'(words); cfg_rows = 9'(nrows - 1); cfg_acd = 4'(acdn - 1);
      rows = nrows; nfr = nframes;
      beats = (words + 1) * 8 / lanes();
      reqcnt = 0; bc = 0; lpw = 0; lines = 0; frames = 0; lc = 0; prevrow = 0;
      pprev = 1'b0;
      #1;
      chk(lclk == cfg_pol[0] && lp == cfg_pol[1] && flm == cfg_pol[2],
          "R6 idle levels", int'({flm, lp, lclk}), int'(cfg_pol));
      acd0 = lacd;
      run_on = 1'b1;
      en = 1'b1;
      wait (frames == nfr);
      #1;
      en = 1'b0;
      repeat (300) @(negedge clk);
      #1;
      chk(bc == beats, "R11 halt completes the line", bc, beats);
      chk(reqcnt == lines + 1, "R4 R11 request count", reqcnt, lines + 1);
      chk(ld == 4'd0 && lclk == cfg_pol[0] && lp == cfg_pol[1] && flm == cfg_pol[2],
          "R11 R6 halted outputs", int'({flm, lp, lclk, ld}), int'({cfg_pol, 4'd0}));
      run_on = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(ld == 4'd0 && !lclk && !lp && !flm && !lacd && !buf_req, "R12 reset state",
          int'({buf_req, lacd, flm, lp, lclk, ld}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      for (int bus = 0; bus < 4; bus++)
         for (int inv = 0; inv < 2; inv++)
            for (int rev = 0; rev < 2; rev++)
               run_cfg(bus, inv[0], rev[0], (bus * 3 + inv + rev * 2) % 8,
                       1 + (bus % 2), 3, 1 + ((bus + inv + rev) % 4),
                       2 * (1 + ((bus + inv + rev) % 4)) + 1);
      run_cfg(2, 1'b0, 1'b0, 7, 0, 1, 16, 33);
      run_cfg(0, 1'b1, 1'b1, 5, 0, 2, 1, 3);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      wait (cycles > 200000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 200000);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule